// File: doc/BRIEF.md
# Data-Processing ALU with Condition-Flag Update

This unit carries out eight data-processing operations of a 32-bit integer core. It covers the logical, move and compare groups. Each issued operation takes operand A (the first source register value) and operand B (the already shifted second operand). It returns one registered result together with a set of strobes: a destination-register write-enable, an updated NZCV flag nibble, a jump request, a status-restore request and a cycle cost. The core's sequencer uses the cycle cost to account for time.

An operation is presented for one cycle with `issue` high. All results appear on the outputs one clock edge later, and they are all qualified in that same cycle. The compare and test operations only change flags. The write operations either write the destination register, or, when the destination is the program counter (index 15), turn into a word-aligned jump. Operation codes the unit does not implement raise an undefined-instruction strobe and change no visible state.

Top module: `dp_alu_flags`

## Requirements
- R1: `opCode` values 8..15 select test-AND, test-XOR, compare-subtract, compare-add, OR, move, bit-clear and move-NOT, in that order. Values 0..7 are unsupported. One cycle after such an issue, `undefOp` is 1, and `resValid`, `rdWe`, `flagsWe`, `jumpReq` and `cycleCost` are 0. `result` keeps its previous value and `flagsOut` equals the flags presented with the issue.
- R2: Every output is registered and reflects the issue of the previous cycle. Back-to-back issues give back-to-back results. In a cycle that follows no issue, all strobes are 0 and `cycleCost` is 0.
- R3: Test-AND (A&B) and test-XOR (A^B) drive `result` and update flags whatever the S bit. N is result bit 31, Z is set when the result is zero, C is `shiftCarry`, and V is kept. They never write a register.
- R4: Compare-subtract computes A-B and never writes a register or jumps, even with destination 15. C is set when A>=B unsigned, and V is set when the operand signs differ and the result sign differs from A. N and Z follow the result.
- R5: Compare-add computes A+B and never writes. C is the unsigned carry out, and V is set when the operand signs agree and the result sign differs from A. N and Z follow the result.
- R6: OR gives A|B, move gives B, bit-clear gives A&~B and move-NOT gives ~B. With a destination other than 15, `rdWe` is 1 and `rdOut` equals `rdIdx`.
- R7: For the four write operations with S=1, `flagsWe` is 1, N and Z follow the result, C is `shiftCarry` and V is kept. With S=0, `flagsWe` is 0 and `flagsOut` equals `flagsIn`. The flag nibble is ordered N,Z,C,V from bit 3 down to bit 0.
- R8: A write operation with destination 15 sets `jumpReq`, does not set `rdWe`, and gives `jumpTarget` equal to the result with bits 1:0 cleared. `restoreReq` is also set when S=1.
- R9: `cycleCost` is 1 for an executed operation and 3 when it jumps, plus 1 when `shiftByReg` is 1.
- R10: During and straight after reset all strobes, `result`, `jumpTarget`, `flagsOut` and `cycleCost` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation presented this cycle |
| opCode | input | 4 | Operation code (see R1) |
| sBit | input | 1 | Flag-update request for write operations |
| rdIdx | input | 4 | Destination register index |
| opA | input | 32 | Operand A |
| opB | input | 32 | Shifted operand B |
| shiftCarry | input | 1 | Carry out of the shifter |
| shiftByReg | input | 1 | Shift amount came from a register |
| flagsIn | input | 4 | Current NZCV flags |
| resValid | output | 1 | Result of an executed operation |
| result | output | 32 | Operation result |
| rdWe | output | 1 | Destination register write-enable |
| rdOut | output | 4 | Destination register index |
| flagsWe | output | 1 | Flags updated |
| flagsOut | output | 4 | New NZCV flags |
| jumpReq | output | 1 | Program-counter write as jump |
| jumpTarget | output | 32 | Word-aligned jump address |
| restoreReq | output | 1 | Status-restore request with the jump |
| cycleCost | output | 3 | Cycles charged for the operation |
| undefOp | output | 1 | Unsupported operation code issued |

## Verification
Every result, strobe, flag nibble and cycle cost is due exactly one clock edge after the cycle in which `issue` was high. No output has a longer path. The bench drives an operation at a falling edge and lowers `issue` at the next falling edge. It samples all outputs at that moment, halfway between the capturing rising edge and the following one. The back-to-back case samples the first result at the first falling edge and the second result one cycle later. The idle and undefined-code checks read the outputs at the same offset, so a stale or early value shows up as a mismatch.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  // Order matches the low three opcode bits of the supported range.
  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_XOR  = 3'd1,
    FN_SUB  = 3'd2,
    FN_ADD  = 3'd3,
    FN_OR   = 3'd4,
    FN_PASS = 3'd5,
    FN_ANDN = 3'd6,
    FN_NOT  = 3'd7
  } aluFn_e;

  typedef enum logic [1:0] {
    FM_KEEP  = 2'd0,
    FM_LOGIC = 2'd1,
    FM_ARITH = 2'd2
  } flagMode_e;

  typedef struct packed {
    logic      go;
    aluFn_e    fn;
    flagMode_e fm;
  } aluCtl_t;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import dp_alu_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int COST_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [3:0]        opCode,
  input  logic              sBit,
  input  logic [REG_W-1:0]  rdIdx,
  input  logic              shiftByReg,
  output aluCtl_t           ctl,
  output logic              resValid,
  output logic              rdWe,
  output logic [REG_W-1:0]  rdOut,
  output logic              flagsWe,
  output logic              jumpReq,
  output logic              restoreReq,
  output logic [COST_W-1:0] cycleCost,
  output logic              undefOp
);

  localparam logic [REG_W-1:0]  PC_IDX    = {REG_W{1'b1}};
  localparam logic [COST_W-1:0] COST_BASE = COST_W'(1);
  localparam logic [COST_W-1:0] COST_JUMP = COST_W'(3);

  logic supported, isCompare, writes, toPc;
  logic [COST_W-1:0] costNext;

  always_comb begin
    supported = opCode[3];
    isCompare = (opCode[3:2] == 2'b10);
    writes    = supported && !isCompare;
    toPc      = (rdIdx == PC_IDX);
    ctl.go    = issue && supported;
    ctl.fn    = aluFn_e'(opCode[2:0]);
    if (isCompare)
      ctl.fm = opCode[1] ? FM_ARITH : FM_LOGIC;
    else
      ctl.fm = sBit ? FM_LOGIC : FM_KEEP;
    costNext = ((writes && toPc) ? COST_JUMP : COST_BASE) + COST_W'(shiftByReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      rdWe       <= 1'b0;
      rdOut      <= '0;
      flagsWe    <= 1'b0;
      jumpReq    <= 1'b0;
      restoreReq <= 1'b0;
      cycleCost  <= '0;
      undefOp    <= 1'b0;
    end else begin
      resValid   <= ctl.go;
      rdWe       <= ctl.go && writes && !toPc;
      rdOut      <= rdIdx;
      flagsWe    <= ctl.go && (ctl.fm != FM_KEEP);
      jumpReq    <= ctl.go && writes && toPc;
      restoreReq <= ctl.go && writes && toPc && sBit;
      cycleCost  <= ctl.go ? costNext : '0;
      undefOp    <= issue && !supported;
    end
  end

  // R3/R4: test and compare codes never write a register or jump
  p_test_no_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(issue && opCode[3:2] == 2'b10) |-> (!rdWe && !jumpReq));

  // R8: restore only accompanies a jump
  p_restore_jump_r8: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq |-> jumpReq);

  // R1: undefined code leaves every update strobe low
  p_undef_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    undefOp |-> (!resValid && !rdWe && !flagsWe && !jumpReq));

  // R9: a jump costs at least three cycles
  p_jump_cost_r9: assert property (@(posedge clk) disable iff (!rstN)
    jumpReq |-> (cycleCost >= COST_JUMP));

endmodule

// File: rtl/dp_alu_path.sv
module dp_alu_path
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  aluCtl_t           ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shiftCarry,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] jumpTarget,
  output logic [3:0]        flagsOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] res;
  logic              nF, zF, cF, vF;
  logic [3:0]        newFlags;

  always_comb begin
    if (ctl.fn == FN_SUB)
      sum = {1'b0, opA} + {1'b0, ~opB} + (DATA_W+1)'(1);
    else
      sum = {1'b0, opA} + {1'b0, opB};

    unique case (ctl.fn)
      FN_AND:  res = opA & opB;
      FN_XOR:  res = opA ^ opB;
      FN_SUB:  res = sum[MSB:0];
      FN_ADD:  res = sum[MSB:0];
      FN_OR:   res = opA | opB;
      FN_PASS: res = opB;
      FN_ANDN: res = opA & ~opB;
      FN_NOT:  res = ~opB;
      default: res = '0;
    endcase

    nF = res[MSB];
    zF = (res == '0);
    if (ctl.fm == FM_ARITH) begin
      cF = sum[DATA_W];
      if (ctl.fn == FN_SUB)
        vF = (opA[MSB] ^ opB[MSB]) & (opA[MSB] ^ res[MSB]);
      else
        vF = ~(opA[MSB] ^ opB[MSB]) & (opA[MSB] ^ res[MSB]);
    end else begin
      cF = shiftCarry;
      vF = flagsIn[0];
    end
    newFlags = {nF, zF, cF, vF};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result     <= '0;
      jumpTarget <= '0;
      flagsOut   <= '0;
    end else begin
      if (ctl.go) begin
        result     <= res;
        jumpTarget <= {res[MSB:2], 2'b00};
      end
      if (issue)
        flagsOut <= (ctl.go && ctl.fm != FM_KEEP) ? newFlags : flagsIn;
    end
  end

  // R7: logical flag updates keep V
  p_keep_v_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.go && ctl.fm == FM_LOGIC) |-> (flagsOut[0] == $past(flagsIn[0])));

  // R4: Z tracks a zero result whenever flags change
  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.go && ctl.fm != FM_KEEP) |-> (flagsOut[2] == (result == '0)));

  // R2: result holds when nothing was executed
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ctl.go) |-> $stable(result));

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int COST_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [3:0]        opCode,
  input  logic              sBit,
  input  logic [REG_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              shiftCarry,
  input  logic              shiftByReg,
  input  logic [3:0]        flagsIn,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              rdWe,
  output logic [REG_W-1:0]  rdOut,
  output logic              flagsWe,
  output logic [3:0]        flagsOut,
  output logic              jumpReq,
  output logic [DATA_W-1:0] jumpTarget,
  output logic              restoreReq,
  output logic [COST_W-1:0] cycleCost,
  output logic              undefOp
);

  aluCtl_t ctl;

  dp_alu_ctrl #(.REG_W(REG_W), .COST_W(COST_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issue      (issue),
    .opCode     (opCode),
    .sBit       (sBit),
    .rdIdx      (rdIdx),
    .shiftByReg (shiftByReg),
    .ctl        (ctl),
    .resValid   (resValid),
    .rdWe       (rdWe),
    .rdOut      (rdOut),
    .flagsWe    (flagsWe),
    .jumpReq    (jumpReq),
    .restoreReq (restoreReq),
    .cycleCost  (cycleCost),
    .undefOp    (undefOp)
  );

  dp_alu_path #(.DATA_W(DATA_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .issue      (issue),
    .ctl        (ctl),
    .opA        (opA),
    .opB        (opB),
    .shiftCarry (shiftCarry),
    .flagsIn    (flagsIn),
    .result     (result),
    .jumpTarget (jumpTarget),
    .flagsOut   (flagsOut)
  );

  // R7/R1: without a flag update the nibble mirrors the issued flags
  p_flags_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(issue) && !flagsWe) |-> (flagsOut == $past(flagsIn)));

  // R8: a jump target is word aligned
  p_target_align_r8: assert property (@(posedge clk) disable iff (!rstN)
    jumpReq |-> (jumpTarget[1:0] == 2'b00));

endmodule

// File: tb/dp_alu_flags_bench.sv
`timescale 1ns/1ps
module dp_alu_flags_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  opCode = '0;
  logic        sBit = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        shiftCarry = 1'b0, shiftByReg = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic        resValid, rdWe, flagsWe, jumpReq, restoreReq, undefOp;
  logic [31:0] result, jumpTarget;
  logic [3:0]  rdOut, flagsOut;
  logic [2:0]  cycleCost;

  int nChecks = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  dp_alu_flags u_dp_alu_flags (
    .clk(clk), .rstN(rstN), .issue(issue), .opCode(opCode), .sBit(sBit),
    .rdIdx(rdIdx), .opA(opA), .opB(opB), .shiftCarry(shiftCarry),
    .shiftByReg(shiftByReg), .flagsIn(flagsIn), .resValid(resValid),
    .result(result), .rdWe(rdWe), .rdOut(rdOut), .flagsWe(flagsWe),
    .flagsOut(flagsOut), .jumpReq(jumpReq), .jumpTarget(jumpTarget),
    .restoreReq(restoreReq), .cycleCost(cycleCost), .undefOp(undefOp)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        s;
    logic [3:0]  rd;
    logic [31:0] a;
    logic [31:0] b;
    logic        sc;
    logic        sr;
    logic [3:0]  fin;
    logic [31:0] res;
    logic        we;
    logic        fwe;
    logic [3:0]  fl;
    logic        jmp;
    logic        rsto;
    logic [2:0]  cost;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    {4'd12,1'b0,4'd3, 32'hF0F00000,32'h00000F0F,1'b0,1'b0,4'b0101, 32'hF0F00F0F,1'b1,1'b0,4'b0101,1'b0,1'b0,3'd1},
    {4'd13,1'b1,4'd2, 32'h00000000,32'h80000000,1'b1,1'b1,4'b0000, 32'h80000000,1'b1,1'b1,4'b1010,1'b0,1'b0,3'd2},
    {4'd14,1'b1,4'd4, 32'h000000FF,32'h000000FF,1'b0,1'b0,4'b0011, 32'h00000000,1'b1,1'b1,4'b0101,1'b0,1'b0,3'd1},
    {4'd15,1'b0,4'd5, 32'h00000000,32'h0000FFFF,1'b0,1'b0,4'b1111, 32'hFFFF0000,1'b1,1'b0,4'b1111,1'b0,1'b0,3'd1},
    {4'd8, 1'b0,4'd0, 32'h0000FF00,32'h00000F00,1'b1,1'b0,4'b0100, 32'h00000F00,1'b0,1'b1,4'b0010,1'b0,1'b0,3'd1},
    {4'd9, 1'b1,4'd0, 32'h12345678,32'h12345678,1'b0,1'b1,4'b1001, 32'h00000000,1'b0,1'b1,4'b0101,1'b0,1'b0,3'd2},
    {4'd10,1'b1,4'd0, 32'h00000005,32'h00000003,1'b0,1'b0,4'b1101, 32'h00000002,1'b0,1'b1,4'b0010,1'b0,1'b0,3'd1},
    {4'd10,1'b1,4'd0, 32'h00000003,32'h00000005,1'b1,1'b0,4'b0000, 32'hFFFFFFFE,1'b0,1'b1,4'b1000,1'b0,1'b0,3'd1},
    {4'd10,1'b1,4'd0, 32'h80000000,32'h00000001,1'b0,1'b0,4'b0000, 32'h7FFFFFFF,1'b0,1'b1,4'b0011,1'b0,1'b0,3'd1},
    {4'd11,1'b1,4'd0, 32'hFFFFFFFF,32'h00000001,1'b0,1'b0,4'b0000, 32'h00000000,1'b0,1'b1,4'b0110,1'b0,1'b0,3'd1},
    {4'd11,1'b1,4'd0, 32'h7FFFFFFF,32'h00000001,1'b1,1'b0,4'b0000, 32'h80000000,1'b0,1'b1,4'b1001,1'b0,1'b0,3'd1},
    {4'd13,1'b0,4'd15,32'h00000000,32'h00001003,1'b0,1'b1,4'b0000, 32'h00001003,1'b0,1'b0,4'b0000,1'b1,1'b0,3'd4},
    {4'd12,1'b1,4'd15,32'h00000100,32'h00000002,1'b0,1'b0,4'b0000, 32'h00000102,1'b0,1'b1,4'b0000,1'b1,1'b1,3'd3},
    {4'd10,1'b1,4'd15,32'h00000001,32'h00000001,1'b0,1'b0,4'b0000, 32'h00000000,1'b0,1'b1,4'b0110,1'b0,1'b0,3'd1}
  };
  localparam string TAGS [NV] = '{
    "R6", "R7 R9", "R7", "R6", "R3", "R3 R9", "R4", "R4",
    "R4", "R5", "R5", "R8 R9", "R8", "R8 R4"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opCode = v.op; sBit = v.s; rdIdx = v.rd; opA = v.a; opB = v.b;
    shiftCarry = v.sc; shiftByReg = v.sr; flagsIn = v.fin; issue = 1'b1;
  endtask

  task automatic expectVec(input vec_t v, input string tag);
    chk({tag, " resValid"}, 32'(resValid), 32'd1);
    chk({tag, " result"}, result, v.res);
    chk({tag, " rdWe"}, 32'(rdWe), 32'(v.we));
    if (v.we) chk({tag, " rdOut"}, 32'(rdOut), 32'(v.rd));
    chk({tag, " flagsWe"}, 32'(flagsWe), 32'(v.fwe));
    chk({tag, " flagsOut"}, 32'(flagsOut), 32'(v.fl));
    chk({tag, " jumpReq"}, 32'(jumpReq), 32'(v.jmp));
    if (v.jmp) chk({tag, " jumpTarget"}, jumpTarget, v.res & ~32'h3);
    chk({tag, " restoreReq"}, 32'(restoreReq), 32'(v.rsto));
    chk({tag, " cycleCost"}, 32'(cycleCost), 32'(v.cost));
    chk({tag, " undefOp"}, 32'(undefOp), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    logic [31:0] lastRes;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 resValid", 32'(resValid), 0);
    chk("R10 result", result, 0);
    chk("R10 flagsOut", 32'(flagsOut), 0);
    chk("R10 strobes", 32'({rdWe, flagsWe, jumpReq, restoreReq, undefOp}), 0);
    chk("R10 cycleCost", 32'(cycleCost), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      issue = 1'b0;
      expectVec(VECS[i], TAGS[i]);
    end

    // R2: idle cycle after an issue
    @(negedge clk);
    chk("R2 idle resValid", 32'(resValid), 0);
    chk("R2 idle strobes", 32'({rdWe, flagsWe, jumpReq, restoreReq, undefOp}), 0);
    chk("R2 idle cycleCost", 32'(cycleCost), 0);

    // R1: unsupported code 3
    lastRes = result;
    drive('{op:4'd3, s:1'b1, rd:4'd1, a:32'hAAAA5555, b:32'h1, sc:1'b1, sr:1'b0,
            fin:4'b1100, default:'0});
    @(negedge clk);
    issue = 1'b0;
    chk("R1 undefOp", 32'(undefOp), 1);
    chk("R1 resValid", 32'(resValid), 0);
    chk("R1 writes", 32'({rdWe, flagsWe, jumpReq}), 0);
    chk("R1 result kept", result, lastRes);
    chk("R1 flagsOut", 32'(flagsOut), 32'(4'b1100));
    chk("R1 cycleCost", 32'(cycleCost), 0);

    // R2: back-to-back issues
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[3]);
    expectVec(VECS[0], "R2 b2b first");
    @(negedge clk);
    issue = 1'b0;
    expectVec(VECS[3], "R2 b2b second");

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule